// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block is the write side of an external bus master. An internal requester hands it one write at a time: an address, a data word and the index of the memory bank to select. The sequencer then drives the external address bus, one active-low bank select, an active-low write strobe and a data bus with its own output enable. It watches an acknowledge line from the slow device, so a peripheral that needs more time can stretch the access.

The strobe lasts for a programmed number of wait states, and for longer if the device holds its acknowledge low. Two configuration bits can add cycles after the strobe rises. One keeps the address and select valid for one more clock. The other adds one fully quiet clock before the sequence ends. The configuration is captured when the request is accepted, so changing it during an access has no effect on that access. Every delay is counted in whole clock cycles.

Top module: `xmem_write_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, all bank selects and the write strobe are high, data enable is low, address and data outputs are zero, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The next cycle is a single setup cycle: the address is driven and only `mem_sel_n[bank]` is low, where bit i selects bank i. The write strobe stays high during this cycle. Apart from that select, no select is ever low.
- R3: With the acknowledge held high, the write strobe stays low for exactly W+2 cycles, where W is the 3-bit `cfg_wait` value.
- R4: If the acknowledge is pulled low in the setup cycle and held low for A cycles (A at least 1), the strobe stays low for max(W, A)+2 cycles. This count includes the two-flop synchroniser delay.
- R5: The data enable is low in the first strobe cycle and high in every later strobe cycle. While it is high, `mem_data` equals the request data. The enable is never high while the strobe is high.
- R6: With `cfg_hold_en`=1, the address and select stay valid for exactly one cycle after the strobe rises. With `cfg_hold_en`=0, they are released in the same cycle as the strobe rises.
- R7: With `cfg_idle_en`=1, exactly one cycle with no select and no strobe follows the rest of the sequence before `done`. With `cfg_idle_en`=0, there is no such cycle.
- R8: `done` is a one-cycle pulse in the first ready cycle after a sequence. `req_ready` is high only when the bus is quiet. A `req_valid` pulse while `req_ready` is low starts no access.
- R9: The wait count and both enables are captured at acceptance. A change to `cfg_*` during an access does not change that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_bank | input | $clog2(BANKS) | Bank select index |
| cfg_wait | input | 3 | Wait-state count W |
| cfg_hold_en | input | 1 | Add address-hold cycle |
| cfg_idle_en | input | 1 | Add bus-idle cycle |
| done | output | 1 | Sequence finished pulse |
| mem_addr | output | ADDR_W | External address bus |
| mem_sel_n | output | BANKS | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data | output | DATA_W | External data bus value |
| mem_data_oe | output | 1 | Data bus output enable (bus is tristated when low) |
| ack_in | input | 1 | Asynchronous acknowledge from device |

## Verification
Writes are driven with wait counts 0, 1, 2, 5 and 7 and the acknowledge held high, which isolates the wait-state counter. Other writes pull the acknowledge low for 1, 2 and 4 cycles, so that in some cases the device sets the strobe length and in others the counter does. All four combinations of the hold and idle bits are tried, and the monitor tells them apart by counting selected and quiet cycles after the strobe rises. One access has its configuration rewritten mid-strobe, and a stray request is pulsed while the block is busy. These show that captured settings and the ready handshake govern each access.

// File: rtl/xmw_pkg.sv
package xmw_pkg;

    localparam int WS_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_QUIET  = 3'd4
    } xmw_state_e;

    typedef struct packed {
        logic [WS_W-1:0] waits;
        logic            hold_en;
        logic            idle_en;
    } xmw_cfg_t;

    // State entered once the strobe is released
    function automatic xmw_state_e post_strobe(input xmw_cfg_t c);
        if (c.hold_en)      return ST_HOLD;
        else if (c.idle_en) return ST_QUIET;
        else                return ST_IDLE;
    endfunction

    // State entered after the address-hold cycle
    function automatic xmw_state_e post_hold(input xmw_cfg_t c);
        return c.idle_en ? ST_QUIET : ST_IDLE;
    endfunction

endpackage

// File: rtl/xmw_ack_sync.sv
module xmw_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_async,
    output logic ack_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], ack_async};
    end

    assign ack_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xmw_ctrl.sv
module xmw_ctrl
    import xmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  xmw_cfg_t   cfg_in,
    input  logic       ack_ok,
    output xmw_state_e state,
    output logic       accept,
    output logic       strobe_data,
    output logic       done
);
    localparam int CNT_W = WS_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    xmw_state_e        state_q, state_d;
    xmw_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              wait_over;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign wait_over = cnt_q > {1'b0, cfg_q.waits};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (wait_over && ack_ok) state_d = post_strobe(cfg_q);
            ST_HOLD:   state_d = post_hold(cfg_q);
            ST_QUIET:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (accept) cfg_q <= cfg_in;
            if (state_q != ST_STROBE)  cnt_q <= '0;
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state       = state_q;
    assign strobe_data = (state_q == ST_STROBE) && (cnt_q != '0);
    assign done        = done_q;

    assert_done_in_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_q == ST_IDLE));

    assert_strobe_follows_setup_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP) |=> (state_q == ST_STROBE));

    assert_quiet_needs_cfg_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_QUIET) |-> cfg_q.idle_en);
endmodule

// File: rtl/xmw_pins.sv
module xmw_pins
    import xmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [BANK_W-1:0] bank_in,
    input  xmw_state_e        state,
    input  logic              strobe_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANKS-1:0]  mem_sel_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_data_oe
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [BANK_W-1:0] bank_q;
    logic              bus_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            bank_q <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
            data_q <= data_in;
            bank_q <= bank_in;
        end
    end

    assign bus_active = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

    for (genvar b = 0; b < BANKS; b++) begin : g_sel
        assign mem_sel_n[b] = !(bus_active && (bank_q == BANK_W'(b)));
    end

    assign mem_addr    = bus_active ? addr_q : '0;
    assign mem_wr_n    = (state != ST_STROBE);
    assign mem_data_oe = strobe_data;
    assign mem_data    = strobe_data ? data_q : '0;

    assert_oe_inside_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        mem_data_oe |-> !mem_wr_n);

    assert_addr_released_R6: assert property (@(posedge clk) disable iff (rst)
        (&mem_sel_n) |-> (mem_addr == '0));
endmodule

// File: rtl/xmem_write_seq.sv
module xmem_write_seq
    import xmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [WS_W-1:0]   cfg_wait,
    input  logic              cfg_hold_en,
    input  logic              cfg_idle_en,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANKS-1:0]  mem_sel_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_data_oe,
    input  logic              ack_in
);
    xmw_state_e state;
    xmw_cfg_t   cfg_in;
    logic       ack_s, accept, strobe_data;

    assign cfg_in = '{waits: cfg_wait, hold_en: cfg_hold_en, idle_en: cfg_idle_en};

    xmw_ack_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ack_async(ack_in),
        .ack_sync (ack_s)
    );

    xmw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .cfg_in     (cfg_in),
        .ack_ok     (ack_s),
        .state      (state),
        .accept     (accept),
        .strobe_data(strobe_data),
        .done       (done)
    );

    xmw_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .addr_in    (req_addr),
        .data_in    (req_data),
        .bank_in    (req_bank),
        .state      (state),
        .strobe_data(strobe_data),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_wr_n   (mem_wr_n),
        .mem_data   (mem_data),
        .mem_data_oe(mem_data_oe)
    );

    assign req_ready = (state == ST_IDLE);

    assert_single_select_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_sel_n));

    assert_strobe_needs_select_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> ($countones(~mem_sel_n) == 1));

    assert_setup_before_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> $past(!(&mem_sel_n)));

    assert_no_data_first_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> !mem_data_oe);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_wr_n && (&mem_sel_n) && !mem_data_oe));
endmodule

// File: tb/xmem_write_seq_tb.sv
module xmem_write_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BANKS  = 4;
    localparam int BANK_W = 2;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        int bank, w, a;
        bit hold, idle;
    } exp_t;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_ready, done;
    logic [ADDR_W-1:0] req_addr = '0, mem_addr;
    logic [DATA_W-1:0] req_data = '0, mem_data;
    logic [BANK_W-1:0] req_bank = '0;
    logic [2:0] cfg_wait = '0;
    logic cfg_hold_en = 0, cfg_idle_en = 0, ack_in = 1;
    logic [BANKS-1:0] mem_sel_n;
    logic mem_wr_n, mem_data_oe;

    int tests = 0, fails = 0, pushed = 0, seen = 0;
    bit finished = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank),
        .cfg_wait(cfg_wait), .cfg_hold_en(cfg_hold_en), .cfg_idle_en(cfg_idle_en),
        .done(done), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
        .mem_data(mem_data), .mem_data_oe(mem_data_oe), .ack_in(ack_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int addr, input int data, input int bank,
                        input int w, input bit h, input bit i, input int a);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = ADDR_W'(addr); req_data = DATA_W'(data);
        req_bank = BANK_W'(bank); cfg_wait = 3'(w); cfg_hold_en = h; cfg_idle_en = i;
        e.addr = ADDR_W'(addr); e.data = DATA_W'(data); e.bank = bank;
        e.w = w; e.a = a; e.hold = h; e.idle = i;
        q.push_back(e); pushed++;
        @(negedge clk);
        req_valid = 0;
    endtask

    // Monitor: measures each access at the pins and compares with the queue
    initial begin
        exp_t cur;
        int phase = 0, setup_n = 0, strobe_n = 0, oe_n = 0, hold_n = 0, quiet_n = 0;
        int ack_cnt = 0, data_bad = 0, exp_len = 0;
        bit first_oe = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            if (ack_cnt > 0) begin
                ack_cnt--;
                if (ack_cnt == 0) ack_in = 1;
            end
            case (phase)
                0: if (!(&mem_sel_n)) begin
                    if (q.size() == 0) begin
                        check(0, "R8 unexpected access", 1, 0);
                    end else begin
                        cur = q.pop_front(); seen++;
                        check(mem_sel_n == ~(BANKS'(1) << cur.bank), "R2 select",
                              int'(mem_sel_n), int'(~(BANKS'(1) << cur.bank)));
                        check(mem_addr == cur.addr, "R2 address", int'(mem_addr), int'(cur.addr));
                        if (cur.a > 0) begin ack_in = 0; ack_cnt = cur.a; end
                        setup_n = mem_wr_n ? 1 : 0; strobe_n = 0; oe_n = 0;
                        hold_n = 0; quiet_n = 0; data_bad = 0; first_oe = 0;
                        phase = mem_wr_n ? 1 : 2;
                        if (!mem_wr_n) strobe_n = 1;
                    end
                end
                1: if (mem_wr_n) setup_n++;
                   else begin
                       check(setup_n == 1, "R2 setup cycles", setup_n, 1);
                       first_oe = mem_data_oe; strobe_n = 1; phase = 2;
                   end
                2: if (!mem_wr_n) begin
                       strobe_n++;
                       if (mem_data_oe) begin
                           oe_n++;
                           if (mem_data != cur.data) data_bad++;
                       end
                   end else begin
                       exp_len = ((cur.w > cur.a) ? cur.w : cur.a) + 2;
                       if (cur.a > 0) check(strobe_n == exp_len, "R4 strobe with ack", strobe_n, exp_len);
                       else           check(strobe_n == exp_len, "R3 strobe length", strobe_n, exp_len);
                       check(first_oe == 0, "R5 oe in first strobe cycle", first_oe, 0);
                       check(oe_n == strobe_n - 1, "R5 oe cycles", oe_n, strobe_n - 1);
                       check(data_bad == 0, "R5 data value", data_bad, 0);
                       check(mem_data_oe == 0, "R5 oe after rise", mem_data_oe, 0);
                       phase = 3;
                   end
                default: ;
            endcase
            if (phase == 3) begin
                if (done) begin
                    check(hold_n == int'(cur.hold), "R6 hold cycles", hold_n, int'(cur.hold));
                    check(quiet_n == int'(cur.idle), "R7 quiet cycles", quiet_n, int'(cur.idle));
                    check(req_ready == 1, "R8 ready with done", req_ready, 1);
                    phase = 0;
                end else if (mem_wr_n) begin
                    if (!(&mem_sel_n)) hold_n++;
                    else quiet_n++;
                end
            end
        end
    end

    // Done pulse width, checked apart from the monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                @(negedge clk);
                if (!finished) check(done == 0, "R8 done one cycle", done, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_sel_n == '1 && mem_wr_n && !mem_data_oe && req_ready && !done && mem_addr == 0,
              "R1 reset outputs", int'(mem_sel_n), 15);
        @(negedge clk) rst = 0;
        @(negedge clk);
        check(mem_sel_n == '1 && mem_wr_n && !mem_data_oe && req_ready && !done && mem_data == 0,
              "R1 after reset", int'(mem_wr_n), 1);

        send(16'h1000, 16'hA5A5, 0, 0, 0, 0, 0);
        send(16'h2222, 16'h0F0F, 3, 5, 0, 0, 0);
        send(16'h3300, 16'h1234, 1, 7, 1, 0, 0);
        send(16'h4400, 16'h5555, 2, 1, 0, 1, 0);
        send(16'h5500, 16'hBEEF, 3, 2, 1, 1, 0);
        send(16'h6600, 16'hCAFE, 0, 1, 0, 0, 4);
        send(16'h7700, 16'h0001, 1, 6, 0, 0, 2);
        send(16'h8800, 16'h8000, 2, 0, 1, 0, 1);

        // R9: reconfigure while the access runs
        send(16'h9900, 16'h9999, 1, 2, 0, 0, 0);
        @(negedge clk);
        cfg_wait = 3'd7; cfg_hold_en = 1; cfg_idle_en = 1;
        repeat (3) @(negedge clk);

        // R8: request pulse while busy is ignored
        send(16'hAA00, 16'h7777, 2, 3, 0, 1, 0);
        req_valid = 1; req_bank = 2'd0; req_addr = 16'hDEAD; req_data = 16'hDEAD;
        @(negedge clk);
        req_valid = 0;

        send(16'hBB00, 16'h4321, 0, 4, 1, 1, 3);

        while (q.size() != 0 || !req_ready) @(negedge clk);
        repeat (12) @(negedge clk);
        check(seen == pushed, "R8 access count", seen, pushed);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule